// File: doc/BRIEF.md
# Extended-range capture interval timer

This block timestamps selected falling edges of an asynchronous input and reports the time between them. A 16-bit base counter runs from zero to its maximum on every clock and then wraps. A second word counts the wraps, which gives a 32-bit timestamp. If a capture lands in the same clock cycle as a wrap, the hardware decides which side of the wrap it belongs to. Software therefore never has to resolve the case where a capture and a rollover are flagged together.

Before an edge is used, the input goes through a two-stage synchronizer and a digital stability filter with a configurable length. An optional prescaler can then pass only every eighth falling edge. For each capture the block subtracts the previous 32-bit timestamp from the current one. The result goes into an eight-entry circular buffer, which is read one word per request. The buffer reports its fill level and has a sticky overflow flag.

Top module: `xcap_interval`

## Requirements
- R1: While `rst` is high, on every clock: `fill` becomes 0, `not_empty` 0, `ovf` 0, `rd_data` 0, the extended timestamp becomes 0, and the filtered input level is forced high.
- R2: The low 16 bits of the timestamp count up by one each clock and wrap from 0xFFFF to 0. Each wrap adds 0x00010000 to the timestamp. Intervals longer than 65535 clocks are reported exactly.
- R3: Suppose a rollover is still pending in the cycle of a capture and the captured low word has its top bit clear. Then the upper word is taken as its pre-increment value plus one. The extended timestamp seen by the capture logic rises by exactly one on every clock, including across a wrap.
- R4: Only a high-to-low change of the filtered level is a capture event. A rise never captures. The capture takes effect on the clock edge that follows the clock edge on which the filtered level fell.
- R5: The input is sampled by two flops. The filtered level takes a new value after the synchronized sample has differed from it for `filt_len` consecutive clocks. A `filt_len` of 0 acts as 1. Shorter pulses are ignored.
- R6: With `evt_div_on` = 1, only every 8th falling edge seen while `en` is high is captured. With `evt_div_on` = 0, every such edge is captured. The edge counter advances on every falling edge while `en` is high, whatever the mode.
- R7: The first capture after reset or after `en` rises only stores its timestamp. Each later capture writes (current − previous) mod 2^32 into the buffer and then becomes the previous value.
- R8: While `en` is low, falling edges are ignored. The first-capture state and the prescaler count are both cleared.
- R9: The buffer holds 8 intervals and returns them oldest first. `rd_en` with `fill` = 0 is ignored: `fill` stays 0 and `rd_data` holds. A read loads `rd_data` on that clock edge. `not_empty` equals (`fill` ≠ 0).
- R10: A write while `fill` = 8 with no read replaces the oldest entry, keeps `fill` at 8 and sets `ovf`. `ovf` stays set until a clock with `ovf_clr` high. If a new overflow happens on that same clock, `ovf` stays set.
- R11: A read and a write on the same clock while `fill` = 8 return the oldest entry, store the new one and leave `ovf` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Capture enable |
| sig_async | input | 1 | Asynchronous signal to be measured |
| filt_len | input | 4 | Number of stable clocks the filter requires |
| evt_div_on | input | 1 | 1: capture only every 8th falling edge |
| rd_en | input | 1 | Pop one interval from the buffer |
| ovf_clr | input | 1 | Clear the sticky overflow flag |
| rd_data | output | 32 | Last interval read |
| fill | output | 4 | Number of stored intervals (0 to 8) |
| not_empty | output | 1 | Buffer holds at least one interval |
| ovf | output | 1 | Sticky: an unread interval was overwritten |

## Verification
The interval path is tried four ways. The first uses irregular low and high widths, which tells a correct subtraction apart from off-by-one or stale previous values. The second uses long lows with short highs, which tells falling-edge capture apart from rising-edge capture. The third uses pulses shorter than the filter length, which tells filtering apart from raw edge use. The fourth uses a long train of equal pulses in divide-by-8 mode, which tells the prescaler phase apart from a plain edge count. A gap of about 127k clocks shows that the upper word is carried. A tight burst is placed so that one capture falls exactly in the wrap cycle, and this exposes a wrong choice of side across the wrap. Overflow, a read on an empty buffer and a read that coincides with a write when full each check the buffer bookkeeping separately.

// File: rtl/xcap_pkg.sv
package xcap_pkg;
  localparam int XCAP_LO_W     = 16;
  localparam int XCAP_HI_W     = 16;
  localparam int XCAP_DEPTH    = 8;
  localparam int XCAP_FILT_W   = 4;
  localparam int XCAP_PSC_DIV  = 8;
  localparam int XCAP_SYNC     = 2;
endpackage

// File: rtl/xcap_edge_qual.sv
// Synchronizer, stability filter, falling-edge detect and event prescaler.
module xcap_edge_qual #(
  parameter int FILT_W  = 4,
  parameter int PSC_DIV = 8,
  parameter int SYNC    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              div_on,
  input  logic [FILT_W-1:0] filt_len,
  input  logic              sig_async,
  output logic              evt
);
  localparam int PW = (PSC_DIV > 1) ? $clog2(PSC_DIV) : 1;

  logic [SYNC-1:0]   sq;
  logic              smp;
  logic              lvl, lvl_d;
  logic [FILT_W-1:0] run, lim;
  logic              fall, hit;

  always_ff @(posedge clk) begin
    if (rst) sq <= '1;
    else     sq <= {sq[SYNC-2:0], sig_async};
  end
  assign smp = sq[SYNC-1];

  // zero length behaves as one clock of stability
  assign lim = (filt_len == '0) ? '0 : filt_len - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl   <= 1'b1;
      lvl_d <= 1'b1;
      run   <= '0;
    end else begin
      lvl_d <= lvl;
      if (smp == lvl) begin
        run <= '0;
      end else if (run >= lim) begin
        lvl <= smp;
        run <= '0;
      end else begin
        run <= run + 1'b1;
      end
    end
  end

  assign fall = lvl_d & ~lvl;

  generate
    if (PSC_DIV > 1) begin : g_psc
      logic [PW-1:0] psc;
      always_ff @(posedge clk) begin
        if (rst || !en)  psc <= '0;
        else if (fall)   psc <= (psc == PW'(PSC_DIV-1)) ? '0 : psc + 1'b1;
      end
      assign hit = !div_on || (psc == PW'(PSC_DIV-1));
    end else begin : g_nopsc
      assign hit = 1'b1;
    end
  endgenerate

  assign evt = fall & en & hit;
endmodule

// File: rtl/xcap_timebase.sv
// Free-running low counter plus wrap counter; wrap-cycle side selection.
module xcap_timebase #(
  parameter int LO_W = 16,
  parameter int HI_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  output logic [LO_W+HI_W-1:0] ts
);
  logic [LO_W-1:0] lo;
  logic [HI_W-1:0] hi;
  logic            pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo   <= '0;
      hi   <= '0;
      pend <= 1'b0;
    end else begin
      lo   <= lo + 1'b1;
      pend <= &lo;
      hi   <= hi + HI_W'(pend);
    end
  end

  // low half with a pending wrap: capture belongs after the wrap
  assign ts = {hi + HI_W'(pend & ~lo[LO_W-1]), lo};
endmodule

// File: rtl/xcap_ring.sv
// Circular interval store; overwrite-oldest on full.
module xcap_ring #(
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr,
  input  logic [DW-1:0]                wdata,
  input  logic                         rd,
  input  logic                         clr,
  output logic [DW-1:0]                rdata,
  output logic [$clog2(DEPTH+1)-1:0]   fill,
  output logic                         not_empty,
  output logic                         ovf
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          rd_ok, full, drop;
  logic [CW-1:0] fill_n;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign rd_ok  = rd && (fill != '0);
  assign full   = (fill == CW'(DEPTH));
  assign drop   = wr && full && !rd_ok;
  assign fill_n = fill + CW'(wr && !drop) - CW'(rd_ok);

  always_ff @(posedge clk) begin
    if (wr) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp        <= '0;
      rp        <= '0;
      fill      <= '0;
      not_empty <= 1'b0;
      ovf       <= 1'b0;
      rdata     <= '0;
    end else begin
      if (wr)            wp <= bump(wp);
      if (rd_ok || drop) rp <= bump(rp);
      fill      <= fill_n;
      not_empty <= (fill_n != '0);
      ovf       <= drop ? 1'b1 : (clr ? 1'b0 : ovf);
      if (rd_ok) rdata <= mem[rp];
    end
  end
endmodule

// File: rtl/xcap_interval.sv
module xcap_interval
  import xcap_pkg::*;
#(
  parameter int LO_W    = XCAP_LO_W,
  parameter int HI_W    = XCAP_HI_W,
  parameter int DEPTH   = XCAP_DEPTH,
  parameter int FILT_W  = XCAP_FILT_W,
  parameter int PSC_DIV = XCAP_PSC_DIV,
  parameter int SYNC    = XCAP_SYNC
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       en,
  input  logic                       sig_async,
  input  logic [FILT_W-1:0]          filt_len,
  input  logic                       evt_div_on,
  input  logic                       rd_en,
  input  logic                       ovf_clr,
  output logic [LO_W+HI_W-1:0]       rd_data,
  output logic [$clog2(DEPTH+1)-1:0] fill,
  output logic                       not_empty,
  output logic                       ovf
);
  localparam int TS_W = LO_W + HI_W;

  logic            evt, armed, wr;
  logic [TS_W-1:0] ts_ext, prev_ts, gap;

  xcap_edge_qual #(.FILT_W(FILT_W), .PSC_DIV(PSC_DIV), .SYNC(SYNC)) u_qual (
    .clk(clk), .rst(rst), .en(en), .div_on(evt_div_on),
    .filt_len(filt_len), .sig_async(sig_async), .evt(evt)
  );

  xcap_timebase #(.LO_W(LO_W), .HI_W(HI_W)) u_tb (
    .clk(clk), .rst(rst), .ts(ts_ext)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      armed   <= 1'b0;
      prev_ts <= '0;
    end else if (!en) begin
      armed   <= 1'b0;
    end else if (evt) begin
      armed   <= 1'b1;
      prev_ts <= ts_ext;
    end
  end

  assign wr  = evt & armed;
  assign gap = ts_ext - prev_ts;

  xcap_ring #(.DW(TS_W), .DEPTH(DEPTH)) u_ring (
    .clk(clk), .rst(rst), .wr(wr), .wdata(gap), .rd(rd_en), .clr(ovf_clr),
    .rdata(rd_data), .fill(fill), .not_empty(not_empty), .ovf(ovf)
  );
endmodule

// File: rtl/xcap_checker.sv
module xcap_checker #(
  parameter int TS_W  = 32,
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            rd_en,
  input logic            ovf_clr,
  input logic            wr,
  input logic [TS_W-1:0] ts,
  input logic [CW-1:0]   fill,
  input logic            not_empty,
  input logic            ovf
);
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (fill == '0) && !ovf && !not_empty);

  p_ts_step_r3: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ts == $past(ts) + 1'b1);

  p_fill_bound_r9: assert property (@(posedge clk) disable iff (rst)
    fill <= CW'(DEPTH));

  p_nonempty_r9: assert property (@(posedge clk) disable iff (rst)
    not_empty == (fill != '0));

  p_fill_step_r9: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (fill == $past(fill)) || (fill == $past(fill) + 1'b1) ||
             (fill + 1'b1 == $past(fill)));

  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    ovf && !ovf_clr |=> ovf);

  p_full_write_r10: assert property (@(posedge clk) disable iff (rst)
    (fill == CW'(DEPTH)) && wr && !rd_en |=> ovf && (fill == CW'(DEPTH)));

  p_full_rdwr_r11: assert property (@(posedge clk) disable iff (rst)
    (fill == CW'(DEPTH)) && wr && rd_en && !ovf |=> !ovf && (fill == CW'(DEPTH)));
endmodule

bind xcap_interval xcap_checker #(
  .TS_W(LO_W+HI_W), .DEPTH(DEPTH), .CW($clog2(DEPTH+1))
) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .ovf_clr(ovf_clr), .wr(wr),
  .ts(ts_ext), .fill(fill), .not_empty(not_empty), .ovf(ovf)
);

// File: tb/sim_xcap_interval.sv
module sim_xcap_interval;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic        sig = 1'b1;
  logic        div_on = 1'b0;
  logic        rd_en = 1'b0;
  logic        ovf_clr = 1'b0;
  logic [3:0]  filt_len = 4'd3;
  logic [31:0] rd_data;
  logic [3:0]  fill;
  logic        not_empty, ovf;

  xcap_interval u0 (
    .clk(clk), .rst(rst), .en(en), .sig_async(sig), .filt_len(filt_len),
    .evt_div_on(div_on), .rd_en(rd_en), .ovf_clr(ovf_clr),
    .rd_data(rd_data), .fill(fill), .not_empty(not_empty), .ovf(ovf)
  );

  always #5 clk = ~clk;

  int    n_cmp = 0;
  int    n_bad = 0;
  string cur_req = "R1";

  // behavioural reference state
  logic [31:0] bcyc, m_prev, m_rd, h;
  logic [31:0] mq[$];
  bit          m_ovf, m_arm, m_filt, m_fall, m_flip, m_hit;
  int          m_psc, m_n;

  always @(posedge clk) begin
    if (rst) begin
      bcyc = 0; m_prev = 0; m_rd = 0; h = '1; mq.delete();
      m_ovf = 0; m_arm = 0; m_filt = 1; m_fall = 0; m_psc = 0;
    end else begin
      bcyc = bcyc + 1;
      if (ovf_clr) m_ovf = 0;
      if (rd_en && mq.size() > 0) m_rd = mq.pop_front();
      if (!en) begin
        m_arm = 0; m_psc = 0;
      end else if (m_fall) begin
        m_hit = !div_on || (m_psc == 7);
        m_psc = (m_psc + 1) % 8;
        if (m_hit) begin
          if (m_arm) begin
            if (mq.size() == 8) begin void'(mq.pop_front()); m_ovf = 1; end
            mq.push_back(bcyc - m_prev);
          end
          m_arm = 1; m_prev = bcyc;
        end
      end
      m_n = (filt_len == 0) ? 1 : int'(filt_len);
      m_flip = 1;
      for (int i = 1; i <= m_n; i++) if (h[i] == m_filt) m_flip = 0;
      m_fall = m_flip && m_filt;
      if (m_flip) m_filt = ~m_filt;
      h = {h[30:0], sig};
    end
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    chk("fill", {28'd0, fill}, mq.size());
    chk("not_empty", {31'd0, not_empty}, (mq.size() != 0) ? 32'd1 : 32'd0);
    chk("ovf", {31'd0, ovf}, {31'd0, m_ovf});
    chk("rd_data", rd_data, m_rd);
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(int lo_len, int hi_len);
    sig = 1'b0; tick(lo_len);
    sig = 1'b1; tick(hi_len);
  endtask

  task automatic rd1();
    rd_en = 1'b1; tick(1);
    rd_en = 1'b0; tick(1);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(190000 * 10);
    n_cmp++; n_bad++;
    $display("FAIL watchdog %s actual=running expected=finished", cur_req);
    finish_run();
  end

  initial begin
    cur_req = "R1";
    tick(3);
    rst = 1'b0;
    tick(2);

    cur_req = "R7";
    en = 1'b1; filt_len = 4'd3; tick(4);
    pulse(6, 10); pulse(5, 20); pulse(8, 13); pulse(6, 30); tick(10);

    cur_req = "R9";
    repeat (4) rd1();
    tick(3);

    cur_req = "R4";
    pulse(40, 4); pulse(30, 5); pulse(25, 6); tick(10);
    repeat (3) rd1();

    cur_req = "R5";
    sig = 1'b0; tick(2); sig = 1'b1; tick(12);
    sig = 1'b0; tick(1); sig = 1'b1; tick(10);
    filt_len = 4'd0; tick(2);
    pulse(1, 6); pulse(1, 6); tick(10);
    repeat (3) rd1();

    cur_req = "R6";
    filt_len = 4'd2; div_on = 1'b1;
    repeat (20) pulse(4, 4);
    tick(10);
    repeat (3) rd1();
    div_on = 1'b0;

    cur_req = "R8";
    en = 1'b0;
    repeat (4) pulse(4, 6);
    tick(5); en = 1'b1; tick(3);
    pulse(4, 6); tick(10);
    pulse(4, 9); tick(10);
    repeat (2) rd1();

    cur_req = "R10";
    repeat (11) pulse(4, 6);
    tick(10);
    repeat (2) rd1();
    ovf_clr = 1'b1; tick(1); ovf_clr = 1'b0; tick(3);

    cur_req = "R11";
    repeat (2) pulse(4, 6);
    tick(10);
    sig = 1'b0; tick(4);
    rd_en = 1'b1; tick(1); rd_en = 1'b0;
    sig = 1'b1; tick(10);

    cur_req = "R9";
    repeat (9) rd1();

    cur_req = "R2";
    filt_len = 4'd1; tick(2);
    pulse(4, 6);
    while (bcyc < 32'd131069) tick(1);
    cur_req = "R3";
    repeat (6) pulse(2, 2);
    tick(10);
    cur_req = "R2";
    repeat (2) rd1();
    cur_req = "R3";
    repeat (6) rd1();
    tick(5);
    finish_run();
  end
endmodule